// File: doc/BRIEF.md
# Write-Once Windowed Watchdog Timer

This block is a watchdog peripheral for a system-on-chip. A strobe that marks edges of a slow reference clock feeds a prescaler. The prescaler produces a count tick, and each tick decrements a 12-bit down-counter. When the counter underflows, the block drives a reset pulse. That pulse goes either to the whole system or to the processor alone, depending on configuration. Software keeps the system alive by writing a keyed restart command. A restart is honoured only while the counter sits inside a programmable window near expiry.

The configuration word can be written exactly once after reset. A runaway program therefore cannot turn the watchdog off or stretch its period. The configuration also selects:
- a full disable;
- freezing of the count while a debug input is high;
- whether a restart that arrives too early is treated as a fault that resets the system.

A status word reports sticky underflow and early-restart flags. Reading it clears both flags.

Top module: `wdog_win_top`

## Requirements
- R1: The mode word (address 0) is accepted on the first write after reset only. Its bits are: [11:0] timeout, [23:12] window limit, [24] disable, [25] system-reset enable, [26] processor-reset enable, [27] debug freeze, [28] fault enable. Reading address 0 returns these bits, and later writes to it leave them unchanged. An accepted mode write loads the counter with the new timeout.
- R2: The prescaler emits one count tick for every PRESC_DIV cycles in which `slow_en_i` is high. The counter decrements by one per tick.
- R3: With a timeout of V, the underflow happens on tick V+1 after the load. The counter reloads with V, keeps running, and sets status bit 0.
- R4: A restart is a write to address 1 with 0xA5 in bits [31:24] and bit 0 set. A write with any other key has no effect.
- R5: A keyed restart is accepted only when the count is at or below the window limit, and an accepted restart reloads the counter. A keyed restart above the limit sets status bit 1. If fault enable is also set, that restart reloads the counter and triggers the same reset action as an underflow.
- R6: When the disable bit is set, the counter is frozen, restarts are ignored, and no reset is raised.
- R7: If the system-reset enable is set, a reset action drives only `sys_rst_o`. Otherwise, if the processor-reset enable is set, it drives only `cpu_rst_o`. The two outputs are never high together.
- R8: With the debug-freeze bit set, no tick is counted while `debug_i` is high.
- R9: Reading address 2 returns the flags in bits [1:0] and clears them. A flag that is set in the same cycle survives the read.
- R10: Each reset pulse lasts PULSE_LEN cycles and starts one cycle after the triggering edge. A new reset action restarts the pulse.
- R11: After reset the block has no pulses and no flags. The counter is loaded with 0xFFF, the window limit is 0xFFF, and system reset is enabled. Read data is zero when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_en_i | input | 1 | One-cycle strobe per slow reference clock edge |
| debug_i | input | 1 | Processor is in debug mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 mode, 1 control, 2 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| sys_rst_o | output | 1 | Full system reset pulse |
| cpu_rst_o | output | 1 | Processor-only reset pulse |

## Verification
Every action is taken at the rising edge where its cause is sampled. A counter load, a flag update or a pulse start becomes visible on the following falling edge, and read data is valid during the cycle after the read strobe. The reference model advances on each rising edge from the same inputs, and the outputs are compared on every falling edge, so all expected values are due exactly one edge after their stimulus. The explicit checks count pulse cycles over windows wider than the uncertainty of the prescaler phase, and they read flags only after the event that sets them has passed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned DATA_W = 32;
  localparam logic [7:0]  RESTART_KEY = 8'hA5;

  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_CTRL = 2'd1,
    A_STAT = 2'd2,
    A_RSVD = 2'd3
  } wd_addr_e;

  // packed order matches mode word bits [28:0]
  typedef struct packed {
    logic             fault_en;
    logic             dbg_halt;
    logic             cpu_en;
    logic             sys_en;
    logic             dis;
    logic [CNT_W-1:0] delta;
    logic [CNT_W-1:0] tmo;
  } wd_cfg_t;

  localparam int unsigned CFG_W = $bits(wd_cfg_t);

  localparam wd_cfg_t CFG_RST = '{fault_en: 1'b0, dbg_halt: 1'b0, cpu_en: 1'b0,
                                  sys_en: 1'b1, dis: 1'b0,
                                  delta: {CNT_W{1'b1}}, tmo: {CNT_W{1'b1}}};
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_en_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = slow_en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (slow_en_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              set_uf_i,
  input  logic              set_werr_i,
  output wd_cfg_t           cfg_o,
  output logic              locked_o,
  output logic              mode_load_o,
  output logic [CNT_W-1:0]  load_tmo_o,
  output logic              restart_o
);
  wd_cfg_t           cfg_q;
  logic              locked_q;
  logic              uf_q, werr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              stat_rd;
  logic [DATA_W-1:0] rd_word;

  assign mode_load_o = we_i && (addr_i == A_MODE) && !locked_q;
  assign load_tmo_o  = wdata_i[CNT_W-1:0];
  assign restart_o   = we_i && (addr_i == A_CTRL) &&
                       (wdata_i[DATA_W-1 -: 8] == RESTART_KEY) && wdata_i[0];
  assign stat_rd     = re_i && (addr_i == A_STAT);

  always_comb begin
    rd_word = '0;
    case (addr_i)
      A_MODE:  rd_word[CFG_W-1:0] = cfg_q;
      A_STAT:  rd_word[1:0] = {werr_q, uf_q};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= CFG_RST;
      locked_q <= 1'b0;
    end else if (mode_load_o) begin
      cfg_q    <= wd_cfg_t'(wdata_i[CFG_W-1:0]);
      locked_q <= 1'b1;
    end
  end

  // set wins over clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q   <= 1'b0;
      werr_q <= 1'b0;
    end else begin
      uf_q   <= (uf_q   && !stat_rd) || set_uf_i;
      werr_q <= (werr_q && !stat_rd) || set_werr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rd_word : '0;
  end

  assign rdata_o  = rdata_q;
  assign cfg_o    = cfg_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             debug_i,
  input  wd_cfg_t          cfg_i,
  input  logic             mode_load_i,
  input  logic [CNT_W-1:0] load_tmo_i,
  input  logic             restart_i,
  output logic             set_uf_o,
  output logic             set_werr_o,
  output logic             event_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic keyed, in_win, rs_ok, rs_bad, fault, run, uf;

  assign keyed  = restart_i && !cfg_i.dis;
  assign in_win = cnt_q <= cfg_i.delta;
  assign rs_ok  = keyed && in_win;
  assign rs_bad = keyed && !in_win;
  assign fault  = rs_bad && cfg_i.fault_en;
  assign run    = tick_i && !cfg_i.dis && !(cfg_i.dbg_halt && debug_i);
  assign uf     = !mode_load_i && !rs_ok && !fault && run && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= CFG_RST.tmo;
    else if (mode_load_i)      cnt_q <= load_tmo_i;
    else if (rs_ok || fault)   cnt_q <= cfg_i.tmo;
    else if (run)              cnt_q <= (cnt_q == '0) ? cfg_i.tmo : cnt_q - 1'b1;
  end

  assign set_uf_o   = uf;
  assign set_werr_o = rs_bad;
  assign event_o    = uf || fault;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic kill_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire_i)         cnt_q <= FULL;
    else if (kill_i)         cnt_q <= '0;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = cnt_q != '0;
endmodule

// File: rtl/wdog_win_top.sv
module wdog_win_top
  import wdog_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 128,
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slow_en_i,
  input  logic        debug_i,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sys_rst_o,
  output logic        cpu_rst_o
);
  localparam int unsigned NOUT = 2;  // 0: system, 1: processor

  wd_cfg_t          cfg;
  logic             locked, tick, mode_load, restart;
  logic             set_uf, set_werr, wd_event;
  logic [CNT_W-1:0] load_tmo, cnt;
  logic [NOUT-1:0]  fire, kill, pulse;

  wdog_prescaler #(.DIV(PRESC_DIV)) u_pre (
    .clk_i, .rst_ni, .slow_en_i, .tick_o(tick)
  );

  wdog_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .set_uf_i(set_uf), .set_werr_i(set_werr),
    .cfg_o(cfg), .locked_o(locked), .mode_load_o(mode_load),
    .load_tmo_o(load_tmo), .restart_o(restart)
  );

  wdog_core u_core (
    .clk_i, .rst_ni, .tick_i(tick), .debug_i, .cfg_i(cfg),
    .mode_load_i(mode_load), .load_tmo_i(load_tmo), .restart_i(restart),
    .set_uf_o(set_uf), .set_werr_o(set_werr), .event_o(wd_event), .cnt_o(cnt)
  );

  // system reset dominates processor reset
  assign fire[0] = wd_event && cfg.sys_en;
  assign fire[1] = wd_event && !cfg.sys_en && cfg.cpu_en;
  assign kill[0] = fire[1];
  assign kill[1] = fire[0];

  for (genvar i = 0; i < NOUT; i++) begin : g_pulse
    wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk_i, .rst_ni, .fire_i(fire[i]), .kill_i(kill[i]), .pulse_o(pulse[i])
    );
  end

  assign sys_rst_o = pulse[0];
  assign cpu_rst_o = pulse[1];
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic             debug_i,
  input logic             sys_rst_o,
  input logic             cpu_rst_o,
  input wd_cfg_t          cfg_i,
  input logic             locked_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             tick_i
);
  p_cfg_lock_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i && we_i && addr_i == A_MODE |=> $stable(cfg_i));

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= cfg_i.tmo);

  p_badkey_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_CTRL && wdata_i[31:24] != RESTART_KEY && !tick_i
    |=> $stable(cnt_i));

  p_dis_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.dis |=> $stable(cnt_i));

  p_rst_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sys_rst_o, cpu_rst_o}));

  p_dbg_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.dbg_halt && debug_i && !we_i |=> $stable(cnt_i));
endmodule

bind wdog_win_top wdog_checker u_chk (
  .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
  .debug_i, .sys_rst_o, .cpu_rst_o, .cfg_i(cfg), .locked_i(locked),
  .cnt_i(cnt), .tick_i(tick)
);

// File: tb/tb_wdog_win_top.sv
module tb_wdog_win_top;
  localparam int DIV = 4;
  localparam int PLEN = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slow_en, debug, we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sys_rst, cpu_rst;

  int checks = 0, errors = 0, cyc = 0;
  int sys_hi = 0, cpu_hi = 0;
  int slow_mode = 0;
  string phase = "R11";

  always #2 clk = ~clk;

  wdog_win_top #(.PRESC_DIV(DIV), .PULSE_LEN(PLEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en), .debug_i(debug),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sys_rst_o(sys_rst), .cpu_rst_o(cpu_rst)
  );

  // behavioural reference model
  int m_pre, m_cnt, m_ps, m_pc;
  logic [31:0] m_cfg, m_rd;
  bit m_lock, m_uf, m_we;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 4095; m_ps = 0; m_pc = 0;
      m_cfg = 32'h02FF_FFFF; m_rd = 0; m_lock = 0; m_uf = 0; m_we = 0;
    end else begin
      bit tick, mload, keyed, ok, bad, ev, suf, run, clr;
      int tmo, dlt;
      logic [31:0] rdn;
      tmo = int'(m_cfg[11:0]); dlt = int'(m_cfg[23:12]);
      tick = slow_en && m_pre == DIV - 1;
      if (slow_en) m_pre = tick ? 0 : m_pre + 1;
      rdn = 0;
      if (re && addr == 2'd0) rdn = m_cfg;
      if (re && addr == 2'd2) rdn = {30'd0, m_we, m_uf};
      mload = we && addr == 2'd0 && !m_lock;
      keyed = we && addr == 2'd1 && wdata[31:24] == 8'hA5 && wdata[0] && !m_cfg[24];
      ok = keyed && m_cnt <= dlt;
      bad = keyed && !ok;
      run = tick && !m_cfg[24] && !(m_cfg[27] && debug);
      ev = 0; suf = 0;
      if (mload) m_cnt = int'(wdata[11:0]);
      else if (ok) m_cnt = tmo;
      else if (bad && m_cfg[28]) begin m_cnt = tmo; ev = 1; end
      else if (run) begin
        if (m_cnt == 0) begin m_cnt = tmo; suf = 1; ev = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (ev && m_cfg[25]) begin m_ps = PLEN; m_pc = 0; end
      else if (ev && m_cfg[26]) begin m_pc = PLEN; m_ps = 0; end
      else begin
        if (m_ps > 0) m_ps = m_ps - 1;
        if (m_pc > 0) m_pc = m_pc - 1;
      end
      clr = re && addr == 2'd2;
      m_uf = (m_uf && !clr) || suf;
      m_we = (m_we && !clr) || bad;
      if (mload) begin m_cfg = wdata & 32'h1FFF_FFFF; m_lock = 1; end
      m_rd = rdn;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (sys_rst) sys_hi++;
    if (cpu_rst) cpu_hi++;
    if (rst_n) begin
      checks += 3;
      if (sys_rst !== (m_ps > 0)) begin
        errors++; $display("FAIL %s sys_rst act=%0b exp=%0b @%0d", phase, sys_rst, m_ps > 0, cyc);
      end
      if (cpu_rst !== (m_pc > 0)) begin
        errors++; $display("FAIL %s cpu_rst act=%0b exp=%0b @%0d", phase, cpu_rst, m_pc > 0, cyc);
      end
      if (rdata !== m_rd) begin
        errors++; $display("FAIL %s rdata act=%h exp=%h @%0d", phase, rdata, m_rd, cyc);
      end
    end
  end

  always @(negedge clk) begin
    if (slow_mode == 0) slow_en <= 1'b1;
    else                slow_en <= (cyc % 3) == 0;
  end

  initial begin
    slow_en = 1'b1; debug = 1'b0;
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog expired act=%0d exp<150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int s0, c0;
    // R11 reset state
    do_reset();
    idle(2);
    chk("R11 sys idle", {31'd0, sys_rst}, 0);
    chk("R11 cpu idle", {31'd0, cpu_rst}, 0);
    chk("R11 rdata idle", rdata, 0);
    rd(2'd0, v); chk("R11 mode default", v, 32'h02FF_FFFF);
    rd(2'd2, v); chk("R11 status clear", v, 0);

    // R3 underflow, R10 pulse length
    phase = "R3";
    wr(2'd0, 32'h02FF_F005);
    s0 = sys_hi; idle(30);
    chk("R10 pulse cycles", sys_hi - s0, PLEN);
    rd(2'd2, v); chk("R3 underflow flag", v, 32'h1);
    phase = "R9";
    rd(2'd2, v); chk("R9 clear on read", v, 32'h0);

    // R1 write once
    phase = "R1";
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, v); chk("R1 mode locked", v, 32'h02FF_F005);

    // R4 key check
    phase = "R4";
    idle(30);
    s0 = sys_hi;
    for (int i = 0; i < 10; i++) begin wr(2'd1, 32'hA500_0001); idle(6); end
    chk("R4 keyed restarts hold off reset", sys_hi - s0, 0);
    s0 = sys_hi;
    for (int i = 0; i < 6; i++) begin wr(2'd1, 32'h5A00_0001); idle(6); end
    chk("R4 bad key ignored", (sys_hi - s0) > 0, 1);

    // R5 window and fault, R7 processor only
    phase = "R5";
    do_reset();
    wr(2'd0, 32'h1400_3014);
    s0 = sys_hi; c0 = cpu_hi;
    wr(2'd1, 32'hA500_0001);
    idle(6);
    chk("R7 cpu pulse only", cpu_hi - c0, PLEN);
    chk("R7 no sys pulse", sys_hi - s0, 0);
    rd(2'd2, v); chk("R5 window error flag", v, 32'h2);
    idle(60);
    c0 = cpu_hi;
    wr(2'd1, 32'hA500_0001);
    rd(2'd2, v); chk("R5 in-window restart accepted", v, 32'h0);
    chk("R5 no pulse on accepted restart", cpu_hi - c0, 0);
    idle(100);
    rd(2'd2, v); chk("R5 later underflow", v, 32'h1);

    // R6 disable
    phase = "R6";
    do_reset();
    wr(2'd0, 32'h03FF_F002);
    s0 = sys_hi; c0 = cpu_hi;
    idle(100);
    wr(2'd1, 32'hA500_0001);
    idle(100);
    chk("R6 no reset while disabled", (sys_hi - s0) + (cpu_hi - c0), 0);
    rd(2'd2, v); chk("R6 no flags while disabled", v, 0);

    // R8 debug freeze, R7 system dominates
    phase = "R8";
    do_reset();
    debug = 1'b1;
    wr(2'd0, 32'h0EFF_F003);
    s0 = sys_hi; c0 = cpu_hi;
    idle(120);
    chk("R8 frozen in debug", sys_hi - s0, 0);
    debug = 1'b0;
    idle(24);
    chk("R7 system pulse dominates", sys_hi - s0, PLEN);
    chk("R7 cpu quiet", cpu_hi - c0, 0);

    // R2 irregular slow strobe
    phase = "R2";
    do_reset();
    slow_mode = 1;
    wr(2'd0, 32'h02FF_F002);
    s0 = sys_hi;
    idle(30);
    chk("R2 no underflow before three ticks", sys_hi - s0, 0);
    idle(20);
    chk("R2 underflow after three ticks", sys_hi - s0, PLEN);
    slow_mode = 0;
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule